// File: doc/BRIEF.md
# Per-Pin Direction Parallel Port

An eight-line general-purpose parallel port for a processor bus. Each device-side line works as an input or an output according to its own bit in a programmable direction register. A set bit makes the line an output, driven from an output latch. A clear bit leaves the line as an input; its value is captured when the attached device raises a strobe line. The device side is modelled as three separate vectors: pad input, pad output and pad output enable. The pad drivers themselves sit outside the block.

The processor reaches four registers through a three-bit register select. The access is qualified by a select line from an external address decoder. Each access is a request/acknowledge handshake: `bus_req` is the master's valid and `bus_ack` is the slave's one-cycle reply. The block accepts a request in any cycle where `dec_hit` and `bus_req` are high and `bus_ack` is low. The master must hold `bus_rd`, `reg_sel` and `bus_wdata` stable from raising `bus_req` until it sees `bus_ack`. It must drop `bus_req` in the cycle it sees `bus_ack`; a request still high after that cycle counts as a new access. Back-pressure is implicit: a request waits for as long as `dec_hit` stays low. Towards the device, `dev_strobe` captures input data and `dev_wr_pulse` announces each new output byte. `irq` signals captured data when interrupts are enabled.

Top module: `pio_port`

## Requirements
- R1: A request is accepted at a clock edge where `dec_hit`, `bus_req` are 1 and `bus_ack` is 0. `bus_ack` is then 1 for exactly the next cycle. `bus_rdata` carries the read value in that cycle and is 0 in every other cycle. With `dec_hit` at 0 there is no acknowledge and no register changes.
- R2: After reset the direction register, output latch, interrupt enable and ready flag are all 0. So are `pad_oe`, `pad_out`, `irq`, `bus_ack` and `dev_wr_pulse`.
- R3: Select code 2 is the direction register (read/write). `pad_oe` bit i equals direction bit i, and 1 means output.
- R4: Select code 1 is the output latch (read/write), and `pad_out` always equals it.
- R5: Reading select code 0 returns, bit by bit, the latch bit where the direction bit is 1 and the captured pad bit where it is 0. Writes to code 0 change nothing.
- R6: `dev_wr_pulse` is 1 for exactly one cycle after each write to code 1. That cycle is the acknowledge cycle of the write.
- R7: `dev_strobe` passes through a two-flop synchroniser. A rising edge seen at the synchroniser output captures `pad_in` from the same synchroniser depth and sets the ready flag. Pad changes without a strobe edge are not captured.
- R8: Reading code 0 clears the ready flag. If a strobe edge is detected in the same cycle, the flag stays set.
- R9: Select code 3 is status/control. Bit 0 is the ready flag and is read-only. Bit 1 is the interrupt enable and is read/write. The other bits read 0.
- R10: `irq` is 1 exactly when the ready flag and the interrupt enable are both 1.
- R11: Select codes 4 to 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_hit | input | 1 | Block selected by the external address decoder |
| bus_req | input | 1 | Master request (valid) |
| bus_rd | input | 1 | 1 = read, 0 = write |
| reg_sel | input | 3 | Register select code |
| bus_wdata | input | 8 | Write data |
| bus_ack | output | 1 | Slave acknowledge, one cycle |
| bus_rdata | output | 8 | Read data, valid with `bus_ack` |
| irq | output | 1 | Interrupt request |
| pad_in | input | 8 | Pad input values |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| dev_strobe | input | 1 | Device data-available strobe |
| dev_wr_pulse | output | 1 | Pulse after each output-latch write |

## Verification
The pin read-back is tried with three direction masks: a mixed pattern, all inputs and all outputs. The mixed mask can only pass if the per-bit selection between latch and captured pad is right. The two uniform masks show whether the selection is inverted. Pad values are changed both with and without a strobe edge, which separates real capture from transparent sampling. A random phase then mixes accesses to every select code, including the unmapped ones, with strobes arriving at arbitrary offsets. This reaches the case of a clear and a capture in the same cycle. A behavioural model is compared with every output on every cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int SEL_W = 3;
  typedef enum logic [SEL_W-1:0] {
    SEL_PIN   = 3'd0,
    SEL_LATCH = 3'd1,
    SEL_DIR   = 3'd2,
    SEL_CTRL  = 3'd3
  } pio_sel_e;
  localparam int BIT_READY = 0;
  localparam int BIT_IE    = 1;
endpackage

// File: rtl/pio_bus.sv
module pio_bus #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dec_hit,
  input  logic         bus_req,
  input  logic         bus_rd,
  input  logic [W-1:0] rd_val,
  output logic         wr_en,
  output logic         rd_en,
  output logic         bus_ack,
  output logic [W-1:0] bus_rdata
);
  logic accept;

  assign accept = dec_hit & bus_req & ~bus_ack;
  assign wr_en  = accept & ~bus_rd;
  assign rd_en  = accept & bus_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= accept;
      bus_rdata <= rd_en ? rd_val : '0;
    end
  end

  p_ack_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);
  p_ack_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(dec_hit && bus_req));
  p_rdata_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack |-> (bus_rdata == '0));
endmodule

// File: rtl/pio_capture.sv
module pio_capture #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  input  logic         dev_strobe,
  input  logic         rd_clr,
  output logic [W-1:0] cap_data,
  output logic         in_ready
);
  logic [SYNC-1:0] stb_sh;
  logic [W-1:0]    pad_sh [SYNC];
  logic            stb_prev;
  logic            stb_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_sh   <= '0;
      stb_prev <= 1'b0;
    end else begin
      stb_sh   <= {stb_sh[SYNC-2:0], dev_strobe};
      stb_prev <= stb_sh[SYNC-1];
    end
  end

  generate
    for (genvar s = 0; s < SYNC; s++) begin : g_pad_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pad_sh[s] <= '0;
        else if (s == 0) pad_sh[s] <= pad_in;
        else pad_sh[s] <= pad_sh[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign stb_edge = stb_sh[SYNC-1] & ~stb_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_data <= '0;
      in_ready <= 1'b0;
    end else begin
      if (stb_edge) cap_data <= pad_sh[SYNC-1];
      if (stb_edge) in_ready <= 1'b1;
      else if (rd_clr) in_ready <= 1'b0;
    end
  end

  p_ready_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb_edge |=> in_ready);
  p_ready_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !stb_edge) |=> !in_ready);
  p_cap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_edge |=> $stable(cap_data));
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     cap_data,
  input  logic             in_ready,
  output logic [W-1:0]     latch,
  output logic [W-1:0]     dir,
  output logic             ie,
  output logic             wr_pulse,
  output logic             rd_clr,
  output logic [W-1:0]     rd_val
);
  logic [W-1:0] pin_view;
  logic [W-1:0] status;

  generate
    for (genvar b = 0; b < W; b++) begin : g_pin_mix
      assign pin_view[b] = dir[b] ? latch[b] : cap_data[b];
    end
  endgenerate

  always_comb begin
    status            = '0;
    status[BIT_READY] = in_ready;
    status[BIT_IE]    = ie;
  end

  always_comb begin
    case (reg_sel)
      SEL_PIN:   rd_val = pin_view;
      SEL_LATCH: rd_val = latch;
      SEL_DIR:   rd_val = dir;
      SEL_CTRL:  rd_val = status;
      default:   rd_val = '0;
    endcase
  end

  assign rd_clr = rd_en && (reg_sel == SEL_PIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch    <= '0;
      dir      <= '0;
      ie       <= 1'b0;
      wr_pulse <= 1'b0;
    end else begin
      wr_pulse <= wr_en && (reg_sel == SEL_LATCH);
      if (wr_en) begin
        case (reg_sel)
          SEL_LATCH: latch <= wdata;
          SEL_DIR:   dir   <= wdata;
          SEL_CTRL:  ie    <= wdata[BIT_IE];
          default:   ;
        endcase
      end
    end
  end

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
  p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && reg_sel == SEL_DIR) |=> $stable(dir));
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && reg_sel == SEL_LATCH) |=> $stable(latch));
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_hit,
  input  logic             bus_req,
  input  logic             bus_rd,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [W-1:0]     bus_wdata,
  output logic             bus_ack,
  output logic [W-1:0]     bus_rdata,
  output logic             irq,
  input  logic [W-1:0]     pad_in,
  output logic [W-1:0]     pad_out,
  output logic [W-1:0]     pad_oe,
  input  logic             dev_strobe,
  output logic             dev_wr_pulse
);
  logic         wr_en, rd_en, rd_clr, in_ready, ie;
  logic [W-1:0] rd_val, cap_data;

  pio_bus #(.W(W)) u_bus (
    .clk(clk), .rst_n(rst_n), .dec_hit(dec_hit), .bus_req(bus_req),
    .bus_rd(bus_rd), .rd_val(rd_val), .wr_en(wr_en), .rd_en(rd_en),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  pio_capture #(.W(W), .SYNC(SYNC)) u_cap (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .dev_strobe(dev_strobe),
    .rd_clr(rd_clr), .cap_data(cap_data), .in_ready(in_ready)
  );

  pio_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .reg_sel(reg_sel), .wdata(bus_wdata), .cap_data(cap_data),
    .in_ready(in_ready), .latch(pad_out), .dir(pad_oe), .ie(ie),
    .wr_pulse(dev_wr_pulse), .rd_clr(rd_clr), .rd_val(rd_val)
  );

  assign irq = in_ready & ie;

  p_pulse_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr_pulse |-> (bus_ack && $past(!bus_rd && reg_sel == SEL_LATCH)));
  p_no_irq_without_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ie && in_ready));
endmodule

// File: tb/pio_port_bench.sv
module pio_port_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, dec_hit, bus_req, bus_rd, dev_strobe;
  logic [2:0] reg_sel;
  logic [7:0] bus_wdata, pad_in;
  logic       bus_ack, irq, dev_wr_pulse;
  logic [7:0] bus_rdata, pad_out, pad_oe;

  pio_port u_pio_port (
    .clk(clk), .rst_n(rst_n), .dec_hit(dec_hit), .bus_req(bus_req),
    .bus_rd(bus_rd), .reg_sel(reg_sel), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .irq(irq), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .dev_strobe(dev_strobe),
    .dev_wr_pulse(dev_wr_pulse)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // behavioural reference state
  logic [7:0] m_dout, m_dir, m_cap, m_rdata, m_p1, m_p2;
  logic       m_ie, m_rdy, m_ack, m_c2, m_s1, m_s2, m_cp;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    logic acc, edg;
    logic [7:0] rv;
    if (!rst_n) begin
      m_dout = 0; m_dir = 0; m_cap = 0; m_rdata = 0; m_p1 = 0; m_p2 = 0;
      m_ie = 0; m_rdy = 0; m_ack = 0; m_c2 = 0; m_s1 = 0; m_s2 = 0; m_cp = 0;
    end else begin
      acc = dec_hit && bus_req && !m_ack;
      edg = m_s2 && !m_cp;
      case (reg_sel)
        3'd0: rv = (m_dout & m_dir) | (m_cap & ~m_dir);
        3'd1: rv = m_dout;
        3'd2: rv = m_dir;
        3'd3: rv = {6'b0, m_ie, m_rdy};
        default: rv = 8'h00;
      endcase
      if (edg) m_cap = m_p2;
      if (edg) m_rdy = 1'b1;
      else if (acc && bus_rd && reg_sel == 3'd0) m_rdy = 1'b0;
      if (acc && !bus_rd) begin
        if (reg_sel == 3'd1) m_dout = bus_wdata;
        if (reg_sel == 3'd2) m_dir = bus_wdata;
        if (reg_sel == 3'd3) m_ie = bus_wdata[1];
      end
      m_c2 = acc && !bus_rd && reg_sel == 3'd1;
      m_rdata = (acc && bus_rd) ? rv : 8'h00;
      m_ack = acc;
      m_cp = m_s2; m_s2 = m_s1; m_s1 = dev_strobe;
      m_p2 = m_p1; m_p1 = pad_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 bus_ack", {7'b0, bus_ack}, {7'b0, m_ack});
      chk("R1 bus_rdata", bus_rdata, m_rdata);
      chk("R3 pad_oe", pad_oe, m_dir);
      chk("R4 pad_out", pad_out, m_dout);
      chk("R6 dev_wr_pulse", {7'b0, dev_wr_pulse}, {7'b0, m_c2});
      chk("R10 irq", {7'b0, irq}, {7'b0, m_rdy & m_ie});
    end
  end

  task automatic access(input logic rd, input logic [2:0] rs, input logic [7:0] wd,
                        output logic [7:0] q);
    @(negedge clk);
    dec_hit = 1'b1; bus_req = 1'b1; bus_rd = rd; reg_sel = rs; bus_wdata = wd;
    @(negedge clk);
    while (!bus_ack) @(negedge clk);
    q = bus_rdata;
    bus_req = 1'b0; dec_hit = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); dev_strobe = 1'b1;
    repeat (2) @(negedge clk);
    dev_strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] q, cap;
    rst_n = 0; dec_hit = 0; bus_req = 0; bus_rd = 0; reg_sel = 0;
    bus_wdata = 0; pad_in = 0; dev_strobe = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 pad_oe", pad_oe, 8'h00);
    chk("R2 pad_out", pad_out, 8'h00);
    chk("R2 irq/ack/pulse", {5'b0, irq, bus_ack, dev_wr_pulse}, 8'h00);
    access(1, 3'd3, 0, q); chk("R2 status", q, 8'h00);

    access(0, 3'd2, 8'hA5, q); access(1, 3'd2, 0, q);
    chk("R3 dir readback", q, 8'hA5); chk("R3 pad_oe", pad_oe, 8'hA5);
    access(0, 3'd1, 8'h3C, q); access(1, 3'd1, 0, q);
    chk("R4 latch readback", q, 8'h3C); chk("R4 pad_out", pad_out, 8'h3C);

    pad_in = 8'hF0; cap = 8'hF0; strobe();
    access(1, 3'd3, 0, q); chk("R7 ready set", q, 8'h01);
    access(1, 3'd0, 0, q); chk("R5 mixed read", q, (8'h3C & 8'hA5) | (cap & ~8'hA5));
    access(1, 3'd3, 0, q); chk("R8 ready cleared", q, 8'h00);
    pad_in = 8'h0F;
    repeat (5) @(negedge clk);
    access(1, 3'd0, 0, q); chk("R7 no capture without strobe", q, (8'h3C & 8'hA5) | (cap & ~8'hA5));
    access(0, 3'd0, 8'hFF, q);
    access(1, 3'd1, 0, q); chk("R5 write ignored latch", q, 8'h3C);
    access(1, 3'd2, 0, q); chk("R5 write ignored dir", q, 8'hA5);

    access(0, 3'd3, 8'h03, q); access(1, 3'd3, 0, q);
    chk("R9 ready read-only, ie set", q, 8'h02);
    chk("R10 irq low without ready", {7'b0, irq}, 8'h00);
    cap = 8'h0F; strobe();
    chk("R10 irq high", {7'b0, irq}, 8'h01);
    access(1, 3'd0, 0, q);
    chk("R10 irq after clear", {7'b0, irq}, 8'h00);

    for (int c = 4; c < 8; c++) begin
      access(0, 3'(c), 8'hFF, q); access(1, 3'(c), 0, q);
      chk("R11 unmapped read", q, 8'h00);
    end
    access(1, 3'd1, 0, q); chk("R11 latch unchanged", q, 8'h3C);
    access(1, 3'd2, 0, q); chk("R11 dir unchanged", q, 8'hA5);
    access(1, 3'd3, 0, q); chk("R11 ctrl unchanged", q, 8'h02);

    @(negedge clk);
    dec_hit = 0; bus_req = 1; bus_rd = 0; reg_sel = 3'd1; bus_wdata = 8'h00;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk("R1 no ack unselected", {7'b0, bus_ack}, 8'h00);
    end
    bus_req = 0;
    access(1, 3'd1, 0, q); chk("R1 unselected write no effect", q, 8'h3C);

    access(0, 3'd2, 8'hFF, q); access(1, 3'd0, 0, q);
    chk("R5 all outputs", q, 8'h3C);
    access(0, 3'd2, 8'h00, q); access(1, 3'd0, 0, q);
    chk("R5 all inputs", q, cap);

    for (int n = 0; n < 400; n++) begin
      pad_in = 8'($urandom);
      if ($urandom_range(0, 2) == 0) dev_strobe = ~dev_strobe;
      access(1'($urandom), 3'($urandom), 8'($urandom), q);
    end
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule